// File: doc/BRIEF.md
# SPI Controller Interrupt Register Bank

This block holds the interrupt and status registers of a memory-mapped SPI master. The CPU reaches it through a simple register port: an address, a write strobe, write data and a combinational read-data return. The serial datapath drives four event inputs into it: the current TX FIFO fill count, a TX full level, an RX not-empty level and a mode-fault pulse. The bank latches these events into a status word and keeps a separate interrupt mask. It drives one level-sensitive interrupt line.

The mask is never written directly. Software turns mask bits on through one write-only address and turns them off through another. A read-only address returns the resulting mask. Status bits are cleared by writing ones to them, so software can write back exactly the word it has just read.

The TX overwater event comes from comparing the TX fill count with a programmable watermark. The bank also holds the controller enable bit, which it drives out to the datapath.

Top module: `spi_irq_regbank`

## Requirements
- R1: After reset, the status word reads 0, the mask reads 0, the enable bit and `ctrl_en` are 0, the watermark reads 1 and `irq` is 0.
- R2: Reads decode as follows: 0x04 returns status in bits [6:0], 0x10 returns the mask in bits [6:0], 0x14 returns the enable in bit 0, and 0x28 returns the watermark in bits [CNT_W-1:0]. The write-only addresses 0x08 and 0x0C, and every unmapped address such as 0x00, read as 0.
- R3: A write to 0x08 sets every mask bit whose data bit is 1 and leaves every mask bit whose data bit is 0 unchanged.
- R4: A write to 0x0C clears every mask bit whose data bit is 1 and leaves every mask bit whose data bit is 0 unchanged.
- R5: A write to 0x04 clears each status bit written as 1 and leaves each status bit written as 0 unchanged.
- R6: Status bit 1 (mode fault) is set on the clock edge after a `mode_fault` pulse and stays set until it is cleared. If a pulse and a clear of that bit occur in the same cycle, the bit stays set.
- R7: Status bit 4 (RX not empty) and status bit 3 (TX full) are set on every cycle that their input is high. A clear has no lasting effect while the input stays high, and the bit stays set after the input falls until software clears it.
- R8: Status bit 2 (TX overwater) is set on every cycle in which `tx_count` is strictly below the watermark. A count equal to or above the watermark sets nothing.
- R9: `irq` is high exactly when some status bit and the matching mask bit are both 1. A pending status bit whose mask bit is 0 leaves `irq` low.
- R10: A write to 0x14 loads data bit 0 into the enable register, which drives `ctrl_en`. Writing 0 there disables the controller.
- R11: Only mask bits [6:0] exist. Data bits above bit 6 written to 0x08 have no effect. Status bits 0, 5 and 6 have no event source and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| tx_count | input | CNT_W | Current TX FIFO fill count |
| tx_full | input | 1 | TX FIFO full level |
| rx_not_empty | input | 1 | RX FIFO holds data level |
| mode_fault | input | 1 | Mode fault event pulse |
| irq | output | 1 | Level interrupt request |
| ctrl_en | output | 1 | Controller enable |

## Verification
The bench builds the block with the default 8-bit address and 32-bit data, and narrows `CNT_W` to 5. With a 5-bit count, the all-ones corner is reachable: the watermark and the count can both be set to 31, and the bench checks that an equal count raises no overwater event. The narrow width also brings both sides of the strict compare, at 19 and 20 against a watermark of 20, within a few cycles. The 32-bit data path lets a write of all ones probe that mask bits above bit 6 are absent.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  // Register byte offsets; software depends on these
  localparam int unsigned OFS_STATUS = 'h04;
  localparam int unsigned OFS_MSET   = 'h08;
  localparam int unsigned OFS_MCLR   = 'h0C;
  localparam int unsigned OFS_MASK   = 'h10;
  localparam int unsigned OFS_ENABLE = 'h14;
  localparam int unsigned OFS_WMARK  = 'h28;

  // Shared bit layout of status and mask
  localparam int unsigned IRQ_BITS    = 7;
  localparam int unsigned BIT_MODF    = 1;
  localparam int unsigned BIT_TXOVER  = 2;
  localparam int unsigned BIT_TXFULL  = 3;
  localparam int unsigned BIT_RXAVAIL = 4;

  // Status bits that have an event source
  localparam logic [IRQ_BITS-1:0] SRC_BITS =
    IRQ_BITS'((1 << BIT_MODF) | (1 << BIT_TXOVER) |
              (1 << BIT_TXFULL) | (1 << BIT_RXAVAIL));

  typedef logic [IRQ_BITS-1:0] irq_vec_t;

  typedef struct packed {
    logic status;
    logic mset;
    logic mclr;
    logic enable;
    logic wmark;
  } wr_strb_t;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_STATUS,
    RSEL_MASK,
    RSEL_ENABLE,
    RSEL_WMARK
  } rsel_t;

endpackage

// File: rtl/spi_irq_rst_sync.sv
module spi_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_strb_t          wr,
  output rsel_t             rsel
);
  logic hit_status, hit_mset, hit_mclr, hit_mask, hit_en, hit_wm;

  always_comb begin
    hit_status = (addr == ADDR_W'(OFS_STATUS));
    hit_mset   = (addr == ADDR_W'(OFS_MSET));
    hit_mclr   = (addr == ADDR_W'(OFS_MCLR));
    hit_mask   = (addr == ADDR_W'(OFS_MASK));
    hit_en     = (addr == ADDR_W'(OFS_ENABLE));
    hit_wm     = (addr == ADDR_W'(OFS_WMARK));
  end

  always_comb begin
    wr.status = we & hit_status;
    wr.mset   = we & hit_mset;
    wr.mclr   = we & hit_mclr;
    wr.enable = we & hit_en;
    wr.wmark  = we & hit_wm;
  end

  // Write-only and unmapped offsets select nothing
  always_comb begin
    if (hit_status)    rsel = RSEL_STATUS;
    else if (hit_mask) rsel = RSEL_MASK;
    else if (hit_en)   rsel = RSEL_ENABLE;
    else if (hit_wm)   rsel = RSEL_WMARK;
    else               rsel = RSEL_NONE;
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_en,
  input  logic     clr_en,
  input  irq_vec_t bits,
  output irq_vec_t mask
);
  irq_vec_t mask_q, mask_d;
  logic     mask_ce;

  always_comb begin
    mask_ce = set_en | clr_en;
    mask_d  = mask_q;
    if (set_en) mask_d = mask_q | bits;
    if (clr_en) mask_d = mask_d & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t set_vec,
  input  logic     clr_en,
  input  irq_vec_t clr_bits,
  output irq_vec_t status
);
  for (genvar b = 0; b < IRQ_BITS; b++) begin : g_bit
    if (SRC_BITS[b]) begin : g_src
      logic st_q, st_d;
      // An arriving event wins over a clear in the same cycle
      always_comb st_d = (st_q & ~(clr_en & clr_bits[b])) | set_vec[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= st_d;
      end
      assign status[b] = st_q;
    end else begin : g_none
      assign status[b] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_irq_wmark.sv
module spi_irq_wmark #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned WM_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] tx_count,
  output logic [CNT_W-1:0] wmark,
  output logic             below
);
  logic [CNT_W-1:0] wm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wm_q <= CNT_W'(WM_RST);
    else if (wr_en) wm_q <= wr_val;
  end

  assign wmark = wm_q;
  assign below = (tx_count < wm_q);
endmodule

// File: rtl/spi_irq_regbank.sv
module spi_irq_regbank
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              tx_full,
  input  logic              rx_not_empty,
  input  logic              mode_fault,
  output logic              irq,
  output logic              ctrl_en
);
  localparam int unsigned USED_W = (CNT_W > IRQ_BITS) ? CNT_W : IRQ_BITS;

  logic             rst_q_n;
  wr_strb_t         wr;
  rsel_t            rsel;
  irq_vec_t         mask, status, set_vec;
  irq_vec_t         wbits;
  logic [CNT_W-1:0] wmark;
  logic             below;
  logic             en_q;
  logic             unused_wdata;

  assign wbits        = reg_wdata[IRQ_BITS-1:0];
  assign unused_wdata = ^reg_wdata[DATA_W-1:USED_W];

  spi_irq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  spi_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .we   (reg_we),
    .wr   (wr),
    .rsel (rsel)
  );

  spi_irq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_en (wr.mset),
    .clr_en (wr.mclr),
    .bits   (wbits),
    .mask   (mask)
  );

  spi_irq_wmark #(.CNT_W(CNT_W), .WM_RST(1)) u_wm (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (wr.wmark),
    .wr_val   (reg_wdata[CNT_W-1:0]),
    .tx_count (tx_count),
    .wmark    (wmark),
    .below    (below)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[BIT_MODF]    = mode_fault;
    set_vec[BIT_TXOVER]  = below;
    set_vec[BIT_TXFULL]  = tx_full;
    set_vec[BIT_RXAVAIL] = rx_not_empty;
  end

  spi_irq_status u_stat (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .set_vec  (set_vec),
    .clr_en   (wr.status),
    .clr_bits (wbits),
    .status   (status)
  );

  // Controller enable register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      en_q <= 1'b0;
    else if (wr.enable) en_q <= reg_wdata[0];
  end

  assign ctrl_en = en_q;
  assign irq     = |(status & mask);

  always_comb begin
    reg_rdata = '0;
    unique case (rsel)
      RSEL_STATUS: reg_rdata[IRQ_BITS-1:0] = status;
      RSEL_MASK:   reg_rdata[IRQ_BITS-1:0] = mask;
      RSEL_ENABLE: reg_rdata[0]            = en_q;
      RSEL_WMARK:  reg_rdata[CNT_W-1:0]    = wmark;
      default:     reg_rdata               = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_regbank_chk.sv
module spi_irq_regbank_chk
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              mode_fault,
  input logic              irq,
  input irq_vec_t          mask,
  input irq_vec_t          status
);
  logic wr_set, wr_clr, wr_st;
  assign wr_set = we && (addr == ADDR_W'(OFS_MSET));
  assign wr_clr = we && (addr == ADDR_W'(OFS_MCLR));
  assign wr_st  = we && (addr == ADDR_W'(OFS_STATUS));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask & $past(wdata[IRQ_BITS-1:0])) == $past(wdata[IRQ_BITS-1:0])));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask & $past(wdata[IRQ_BITS-1:0])) == '0));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(mask));

  // R6
  modf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> status[BIT_MODF]);

  // R5
  modf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && wdata[BIT_MODF] && !mode_fault) |=> !status[BIT_MODF]);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && mask[BIT_MODF] && !wr_clr) |=> irq);

  // R2
  wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(OFS_MSET) || addr == ADDR_W'(OFS_MCLR)) |-> (rdata == '0));
endmodule

bind spi_irq_regbank spi_irq_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .addr       (reg_addr),
  .we         (reg_we),
  .wdata      (reg_wdata),
  .rdata      (reg_rdata),
  .mode_fault (mode_fault),
  .irq        (irq),
  .mask       (mask),
  .status     (status)
);

// File: tb/test_spi_irq_regbank.sv
`timescale 1ns/100ps
module test_spi_irq_regbank;
  localparam int AW = 8, DW = 32, CW = 5;
  localparam logic [7:0] A_ST = 8'h04, A_SET = 8'h08, A_CLR = 8'h0C,
                         A_MSK = 8'h10, A_EN = 8'h14, A_WM = 8'h28;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] reg_addr;
  logic reg_we;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [CW-1:0] tx_count;
  logic tx_full, rx_not_empty, mode_fault, irq, ctrl_en;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_irq_regbank #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_spi_irq_regbank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_count(tx_count),
    .tx_full(tx_full), .rx_not_empty(rx_not_empty), .mode_fault(mode_fault),
    .irq(irq), .ctrl_en(ctrl_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_ST, d);  chk("R1 status", d, 0);
    rd(A_MSK, d); chk("R1 mask", d, 0);
    rd(A_EN, d);  chk("R1 enable", d, 0);
    rd(A_WM, d);  chk("R1 watermark", d, 1);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 ctrl_en", {31'b0, ctrl_en}, 0);
    rd(8'h00, d); chk("R2 unmapped read", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(A_SET, 32'h14); rd(A_MSK, d); chk("R3 set", d, 32'h14);
    wr(A_SET, 32'h02); rd(A_MSK, d); chk("R3 set keeps others", d, 32'h16);
    wr(A_SET, 32'h00); rd(A_MSK, d); chk("R3 zero write", d, 32'h16);
    wr(A_CLR, 32'h04); rd(A_MSK, d); chk("R4 clear", d, 32'h12);
    wr(A_CLR, 32'h00); rd(A_MSK, d); chk("R4 zero write", d, 32'h12);
    wr(A_SET, 32'hFFFF_FFFF); rd(A_MSK, d); chk("R11 upper bits", d, 32'h7F);
    rd(A_SET, d); chk("R2 set addr reads 0", d, 0);
    rd(A_CLR, d); chk("R2 clr addr reads 0", d, 0);
    rd(A_ST, d);  chk("R11 unsourced status bits", d & 32'h61, 0);
    wr(A_CLR, 32'h7F); rd(A_MSK, d); chk("R4 clear all", d, 0);
  endtask

  task automatic t_modf;
    logic [31:0] d;
    @(negedge clk); mode_fault = 1'b1;
    @(negedge clk); mode_fault = 1'b0;
    rd(A_ST, d); chk("R6 set", d, 32'h02);
    idle(3); rd(A_ST, d); chk("R6 sticky", d, 32'h02);
    wr(A_ST, 32'h04); rd(A_ST, d); chk("R5 other bit", d, 32'h02);
    wr(A_ST, 32'h02); rd(A_ST, d); chk("R5 cleared", d, 0);
    @(negedge clk);
    reg_addr = A_ST; reg_we = 1'b1; reg_wdata = 32'h02; mode_fault = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; mode_fault = 1'b0;
    rd(A_ST, d); chk("R6 set wins", d, 32'h02);
    wr(A_ST, 32'h02);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    @(negedge clk); rx_not_empty = 1'b1;
    @(negedge clk); rd(A_ST, d); chk("R7 rx set", d, 32'h10);
    wr(A_ST, 32'h10); rd(A_ST, d); chk("R7 rx held", d, 32'h10);
    rx_not_empty = 1'b0; idle(1); rd(A_ST, d); chk("R7 rx sticky", d, 32'h10);
    wr(A_ST, 32'h10); rd(A_ST, d); chk("R7 rx cleared", d, 0);
    tx_full = 1'b1; idle(1); rd(A_ST, d); chk("R7 txfull set", d, 32'h08);
    tx_full = 1'b0; wr(A_ST, 32'h08); rd(A_ST, d); chk("R7 txfull cleared", d, 0);
  endtask

  task automatic t_wmark;
    logic [31:0] d;
    wr(A_WM, 32'd20); rd(A_WM, d); chk("R8 wm read", d, 20);
    idle(1); rd(A_ST, d); chk("R8 below", d, 32'h04);
    tx_count = 5'd25; idle(1); wr(A_ST, 32'h04); rd(A_ST, d); chk("R8 above", d, 0);
    tx_count = 5'd19; idle(1); rd(A_ST, d); chk("R8 one below", d, 32'h04);
    tx_count = 5'd20; idle(1); wr(A_ST, 32'h04); idle(1);
    rd(A_ST, d); chk("R8 equal", d, 0);
    wr(A_WM, 32'd31); tx_count = 5'd31; idle(1); wr(A_ST, 32'h04); idle(1);
    rd(A_ST, d); chk("R8 max equal", d, 0);
    tx_count = 5'd30; idle(1); rd(A_ST, d); chk("R8 max below", d, 32'h04);
    tx_count = 5'd10; wr(A_WM, 32'd1); idle(1); wr(A_ST, 32'h7F);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(A_SET, 32'h10);
    @(negedge clk); mode_fault = 1'b1;
    @(negedge clk); mode_fault = 1'b0;
    chk("R9 masked no irq", {31'b0, irq}, 0);
    wr(A_SET, 32'h02); chk("R9 irq raised", {31'b0, irq}, 1);
    wr(A_CLR, 32'h02); chk("R9 mask off drops irq", {31'b0, irq}, 0);
    wr(A_SET, 32'h02); wr(A_ST, 32'h02); chk("R9 clear drops irq", {31'b0, irq}, 0);
    rd(A_ST, d); chk("R9 status after clear", d, 0);
    wr(A_CLR, 32'h7F);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(A_EN, 32'h1); chk("R10 ctrl_en on", {31'b0, ctrl_en}, 1);
    rd(A_EN, d); chk("R10 read on", d, 1);
    wr(A_EN, 32'h0); chk("R10 ctrl_en off", {31'b0, ctrl_en}, 0);
    rd(A_EN, d); chk("R10 read off", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    tx_count = 5'd10; tx_full = 1'b0; rx_not_empty = 1'b0; mode_fault = 1'b0;
    idle(3); rst_n = 1'b1; idle(3);
    t_reset;
    t_mask;
    t_modf;
    t_levels;
    t_wmark;
    t_irq;
    t_enable;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule